// File: doc/BRIEF.md
# Sweep Waveform DAC Sequencer

This block plays a stored voltage waveform into a group of deflection-supply DACs. There is one wide main DAC of 16 bits and a parameterised number of narrow auxiliary DACs of 8 bits each, three by default. Samples come from a byte-wide lookup RAM that the block reaches through an arbitrated request/acknowledge port. Each DAC owns its own region of that RAM. A divider on the 1 MHz system clock sets the step period, giving roughly 690 steps per second and a full sweep of 1344 samples in about 2 seconds.

On every step the block does two things at once. It applies the samples that were fetched during the previous step to all DAC outputs together, raising a one-cycle update strobe. It then starts fetching the next sample's bytes into holding registers, in one fixed order. The RAM holds two complete waveform tables. A buffer-select input chooses which table plays, but it is sampled only when the sweep wraps to sample 0 (and when the block is enabled), so the host can rewrite the idle table safely. If a fetch has not finished when the next step arrives, that update is skipped and a sticky underrun flag is raised.

The controller has three states:
- `SQ_OFF` moves to `SQ_FETCH` when enable is high.
- `SQ_FETCH` moves to `SQ_READY` when the last byte is acknowledged.
- `SQ_READY` moves to `SQ_FETCH` on a step tick, and this transition applies the held samples.
- From either active state, a low enable returns the controller to `SQ_OFF`.

Top module: `sweep_dac_sequencer`

## Requirements
- R1: After reset, `dac_main`, `dac_aux`, `play_idx` and `play_buf` are 0, and `ram_req`, `dac_update` and `underrun` are low.
- R2: While fetches complete in time, consecutive `dac_update` pulses are exactly `step_div`+1 clock cycles apart.
- R3: Each sample is fetched as NUM_AUX+2 byte requests, always in the same order: main high byte, main low byte, then auxiliary DAC 1, 2 and 3. The RAM address is {buffer (bit 14), region (bits 13:12, main = 0, auxiliary k = k), sample index (bits 11:1), lane (bit 0, 1 = high byte)}. Auxiliary DACs read lane 0.
- R4: On each update, `dac_main` equals {high byte, low byte} from region 0, and `dac_aux[8k-1:8(k-1)]` equals the lane-0 byte of region k. All values come from the sample index and buffer reported on `play_idx` and `play_buf`.
- R5: Every step raises `dac_update` for exactly one cycle and rewrites all outputs, even when the sample values do not change (for example when `last_idx` = 0).
- R6: The played sample index advances by one per update. After index `last_idx` it wraps to 0.
- R7: A change on `buf_cmd` has no effect until the sweep wraps to sample 0. From that point the new buffer is fetched and played.
- R8: A step tick that arrives while bytes are still outstanding sets `underrun`, which stays set. That tick produces no update: the outputs and `play_idx` hold their values. The fetch then continues, and the next tick applies it.
- R9: While `enable` is low there are no RAM requests and no updates, the outputs hold their last values, and `underrun` clears. Raising `enable` again restarts the sweep at sample 0.
- R10: While a request is waiting for acknowledge, `ram_req` stays high and `ram_addr` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the sweep when high |
| step_div | input | DIV_W | Step period minus one, in clock cycles |
| last_idx | input | IDX_W | Index of the final sample before wrap |
| buf_cmd | input | 1 | Requested waveform table |
| ram_req | output | 1 | Byte fetch request |
| ram_addr | output | 2+REG_W+IDX_W | Byte address of the request |
| ram_ack | input | 1 | Request granted; `ram_rdata` is valid |
| ram_rdata | input | 8 | Fetched byte |
| dac_main | output | 16 | Main DAC output register |
| dac_aux | output | NUM_AUX*8 | Auxiliary DAC output registers, DAC 1 in the low byte |
| dac_update | output | 1 | One-cycle strobe while new outputs appear |
| play_idx | output | IDX_W | Sample index now on the outputs |
| play_buf | output | 1 | Table the current outputs came from |
| underrun | output | 1 | Sticky: a step tick arrived before its fetch finished |

## Verification
The hardest case to reach is the underrun: a step tick landing while the controller is still in `SQ_FETCH`. With an ordinary RAM the fetch completes long before the next tick. The bench's RAM responder therefore has an adjustable grant latency. Setting it to seven cycles per byte stretches a five-byte fetch past a 20-cycle step, so the very first tick after enabling finds the fetch unfinished. The bench then confirms that no strobe appeared, that the outputs held, and that the following tick applies sample 0.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;
    typedef enum logic [1:0] {
        SQ_OFF   = 2'd0,
        SQ_FETCH = 2'd1,
        SQ_READY = 2'd2
    } sq_state_t;
endpackage

// File: rtl/sweep_step_timer.sv
module sweep_step_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] step_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == step_div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sweep_fetch_ctrl.sv
module sweep_fetch_ctrl
    import sweep_seq_pkg::*;
#(
    parameter int IDX_W   = 11,
    parameter int NUM_AUX = 3,
    localparam int NBYTES = NUM_AUX + 2,
    localparam int SEL_W  = $clog2(NBYTES),
    localparam int REG_W  = $clog2(NUM_AUX + 1),
    localparam int ADDR_W = 2 + REG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              tick,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              buf_cmd,
    input  logic              ram_ack,
    output logic              ram_req,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              running,
    output logic              load_en,
    output logic [SEL_W-1:0]  load_sel,
    output logic              apply,
    output logic [IDX_W-1:0]  play_idx,
    output logic              play_buf,
    output logic              underrun
);
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(NBYTES - 1);

    sq_state_t        state, nxt;
    logic [IDX_W-1:0] fidx;
    logic             fbuf;
    logic [SEL_W-1:0] bsel;
    logic             apply_c, urun_c;
    logic [REG_W-1:0] region;
    logic             lane;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_OFF;
        else        state <= nxt;
    end

    // Next state and step events
    always_comb begin
        nxt     = state;
        apply_c = 1'b0;
        urun_c  = 1'b0;
        unique case (state)
            SQ_OFF: begin
                if (enable) nxt = SQ_FETCH;
            end
            SQ_FETCH: begin
                if (!enable) nxt = SQ_OFF;
                else begin
                    if (tick) urun_c = 1'b1;
                    if (ram_ack && bsel == LAST_SEL) nxt = SQ_READY;
                end
            end
            SQ_READY: begin
                if (!enable) nxt = SQ_OFF;
                else if (tick) begin
                    apply_c = 1'b1;
                    nxt     = SQ_FETCH;
                end
            end
            default: nxt = SQ_OFF;
        endcase
    end

    // Outputs: fixed byte order maps to region and lane
    always_comb begin
        region   = (bsel < SEL_W'(2)) ? '0 : REG_W'(bsel - 1'b1);
        lane     = (bsel == '0);
        ram_req  = (state == SQ_FETCH);
        ram_addr = {fbuf, region, fidx, lane};
        running  = (state != SQ_OFF);
        load_en  = ram_req && ram_ack;
        load_sel = bsel;
        apply    = apply_c;
    end

    // Sequencing datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fidx     <= '0;
            fbuf     <= 1'b0;
            bsel     <= '0;
            underrun <= 1'b0;
            play_idx <= '0;
            play_buf <= 1'b0;
        end else if (state == SQ_OFF) begin
            fidx     <= '0;
            fbuf     <= buf_cmd;
            bsel     <= '0;
            underrun <= 1'b0;
        end else begin
            if (urun_c) underrun <= 1'b1;
            if (load_en) bsel <= (bsel == LAST_SEL) ? '0 : bsel + 1'b1;
            if (apply_c) begin
                play_idx <= fidx;
                play_buf <= fbuf;
                if (fidx >= last_idx) begin
                    fidx <= '0;
                    fbuf <= buf_cmd;
                end else begin
                    fidx <= fidx + 1'b1;
                end
            end
        end
    end

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_ack && enable) |=> (ram_req && $stable(ram_addr)));

    // R8
    underrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ram_req && enable) |=> underrun);

    // R6
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && fidx < last_idx) |=> (fidx == $past(fidx) + 1'b1));

    // R7
    buf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SQ_OFF && !(apply && fidx >= last_idx)) |=> $stable(fbuf));
endmodule

// File: rtl/sweep_dac_regs.sv
module sweep_dac_regs #(
    parameter int NUM_AUX = 3,
    localparam int NBYTES = NUM_AUX + 2,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [SEL_W-1:0]     load_sel,
    input  logic [7:0]           load_data,
    input  logic                 apply,
    output logic [15:0]          dac_main,
    output logic [NUM_AUX*8-1:0] dac_aux,
    output logic                 dac_update
);
    logic [15:0] main_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_hold  <= '0;
            dac_main   <= '0;
            dac_update <= 1'b0;
        end else begin
            if (load_en && load_sel == SEL_W'(0)) main_hold[15:8] <= load_data;
            if (load_en && load_sel == SEL_W'(1)) main_hold[7:0]  <= load_data;
            if (apply) dac_main <= main_hold;
            dac_update <= apply;
        end
    end

    for (genvar k = 0; k < NUM_AUX; k++) begin : g_aux
        logic [7:0] hold_q;
        logic [7:0] out_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q <= '0;
                out_q  <= '0;
            end else begin
                if (load_en && load_sel == SEL_W'(k + 2)) hold_q <= load_data;
                if (apply) out_q <= hold_q;
            end
        end
        assign dac_aux[k*8 +: 8] = out_q;
    end

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !apply |=> ($stable(dac_main) && $stable(dac_aux)));
endmodule

// File: rtl/sweep_dac_sequencer.sv
module sweep_dac_sequencer #(
    parameter int DIV_W   = 16,
    parameter int IDX_W   = 11,
    parameter int NUM_AUX = 3,
    localparam int NBYTES = NUM_AUX + 2,
    localparam int SEL_W  = $clog2(NBYTES),
    localparam int REG_W  = $clog2(NUM_AUX + 1),
    localparam int ADDR_W = 2 + REG_W + IDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [DIV_W-1:0]     step_div,
    input  logic [IDX_W-1:0]     last_idx,
    input  logic                 buf_cmd,
    output logic                 ram_req,
    output logic [ADDR_W-1:0]    ram_addr,
    input  logic                 ram_ack,
    input  logic [7:0]           ram_rdata,
    output logic [15:0]          dac_main,
    output logic [NUM_AUX*8-1:0] dac_aux,
    output logic                 dac_update,
    output logic [IDX_W-1:0]     play_idx,
    output logic                 play_buf,
    output logic                 underrun
);
    logic             running, tick, load_en, apply;
    logic [SEL_W-1:0] load_sel;

    sweep_step_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(running),
        .step_div(step_div), .tick(tick)
    );

    sweep_fetch_ctrl #(.IDX_W(IDX_W), .NUM_AUX(NUM_AUX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .last_idx(last_idx), .buf_cmd(buf_cmd), .ram_ack(ram_ack),
        .ram_req(ram_req), .ram_addr(ram_addr), .running(running),
        .load_en(load_en), .load_sel(load_sel), .apply(apply),
        .play_idx(play_idx), .play_buf(play_buf), .underrun(underrun)
    );

    sweep_dac_regs #(.NUM_AUX(NUM_AUX)) u_regs (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
        .load_data(ram_rdata), .apply(apply), .dac_main(dac_main),
        .dac_aux(dac_aux), .dac_update(dac_update)
    );
endmodule

// File: tb/sweep_dac_sequencer_test.sv
`timescale 1ns/1ps
module sweep_dac_sequencer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] step_div = 16'd19;
    logic [10:0] last_idx = 11'd3;
    logic        buf_cmd = 1'b0;
    logic        ram_req;
    logic [14:0] ram_addr;
    logic        ram_ack = 1'b0;
    logic [7:0]  ram_rdata = 8'd0;
    logic [15:0] dac_main;
    logic [23:0] dac_aux;
    logic        dac_update;
    logic [10:0] play_idx;
    logic        play_buf;
    logic        underrun;

    int checks = 0;
    int failures = 0;
    int ram_lat = 0;
    int lat_cnt = 0;
    int log_n = 0;
    logic [14:0] addr_log [8];

    sweep_dac_sequencer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .step_div(step_div),
        .last_idx(last_idx), .buf_cmd(buf_cmd), .ram_req(ram_req),
        .ram_addr(ram_addr), .ram_ack(ram_ack), .ram_rdata(ram_rdata),
        .dac_main(dac_main), .dac_aux(dac_aux), .dac_update(dac_update),
        .play_idx(play_idx), .play_buf(play_buf), .underrun(underrun)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic [7:0] byte_of(int a);
        return 8'((a * 13) ^ (a >> 5) ^ 8'h5A);
    endfunction

    function automatic int addr_of(int b, int r, int idx, int lane);
        return (b << 14) | (r << 12) | (idx << 1) | lane;
    endfunction

    // RAM responder with adjustable grant latency
    initial forever begin
        @(negedge clk);
        ram_ack = 1'b0;
        if (!ram_req) lat_cnt = 0;
        else if (lat_cnt >= ram_lat) begin
            ram_ack   = 1'b1;
            ram_rdata = byte_of(int'(ram_addr));
            if (log_n < 8) addr_log[log_n] = ram_addr;
            log_n++;
            lat_cnt = 0;
        end else lat_cnt++;
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_strobe(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!dac_update && cyc < 2000);
        if (cyc >= 2000) check_eq("R5", "strobe timeout", 0, 1);
    endtask

    task automatic check_step(string req, int b, int idx);
        check_eq(req, "play_idx", int'(play_idx), idx);
        check_eq(req, "play_buf", int'(play_buf), b);
        check_eq(req, "dac_main", int'(dac_main),
                 {byte_of(addr_of(b, 0, idx, 1)), byte_of(addr_of(b, 0, idx, 0))});
        for (int k = 1; k <= 3; k++)
            check_eq(req, "dac_aux", int'(dac_aux[(k-1)*8 +: 8]),
                     int'(byte_of(addr_of(b, k, idx, 0))));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "dac_main", int'(dac_main), 0);
        check_eq("R1", "dac_aux", int'(dac_aux), 0);
        check_eq("R1", "ram_req", int'(ram_req), 0);
        check_eq("R1", "dac_update", int'(dac_update), 0);
        check_eq("R1", "underrun", int'(underrun), 0);
        check_eq("R1", "play_idx", int'(play_idx), 0);
    endtask

    task automatic t_sweep();
        int c;
        log_n = 0;
        enable = 1'b1;
        wait_strobe(c);
        check_step("R4", 0, 0);
        check_eq("R3", "byte0 addr", int'(addr_log[0]), addr_of(0, 0, 0, 1));
        check_eq("R3", "byte1 addr", int'(addr_log[1]), addr_of(0, 0, 0, 0));
        for (int k = 1; k <= 3; k++)
            check_eq("R3", "aux addr", int'(addr_log[k+1]), addr_of(0, k, 0, 0));
        for (int i = 1; i <= 4; i++) begin
            wait_strobe(c);
            check_eq("R2", "step period", c, 20);
            check_step("R6", 0, i % 4);
        end
    endtask

    task automatic t_bufswap();
        int c;
        wait_strobe(c);
        check_step("R6", 0, 1);
        buf_cmd = 1'b1;
        wait_strobe(c);
        check_step("R7", 0, 2);
        wait_strobe(c);
        check_step("R7", 0, 3);
        wait_strobe(c);
        check_step("R7", 1, 0);
        wait_strobe(c);
        check_step("R7", 1, 1);
    endtask

    task automatic t_underrun();
        int c;
        int seen_upd;
        int seen_ur;
        logic [15:0] prev;
        enable = 1'b0;
        repeat (5) @(negedge clk);
        prev = dac_main;
        ram_lat = 6;
        enable = 1'b1;
        seen_upd = 0;
        seen_ur = 0;
        for (int i = 0; i < 60 && seen_ur == 0; i++) begin
            @(negedge clk);
            if (dac_update) seen_upd = 1;
            if (underrun) seen_ur = 1;
        end
        check_eq("R8", "underrun raised", seen_ur, 1);
        check_eq("R8", "no update on late tick", seen_upd, 0);
        check_eq("R8", "outputs held", int'(dac_main), int'(prev));
        wait_strobe(c);
        check_step("R8", 1, 0);
        check_eq("R8", "underrun sticky", int'(underrun), 1);
    endtask

    task automatic t_disable();
        int c;
        int bad;
        logic [15:0] m;
        logic [23:0] a;
        enable = 1'b0;
        repeat (2) @(negedge clk);
        m = dac_main;
        a = dac_aux;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ram_req || dac_update) bad++;
        end
        check_eq("R9", "activity while off", bad, 0);
        check_eq("R9", "underrun cleared", int'(underrun), 0);
        check_eq("R9", "main held", int'(dac_main), int'(m));
        check_eq("R9", "aux held", int'(dac_aux), int'(a));
        ram_lat = 0;
        buf_cmd = 1'b0;
        last_idx = 11'd0;
        step_div = 16'd9;
        enable = 1'b1;
        wait_strobe(c);
        check_step("R9", 0, 0);
    endtask

    task automatic t_repeat();
        int c;
        for (int i = 0; i < 3; i++) begin
            wait_strobe(c);
            check_eq("R5", "period", c, 10);
            check_step("R5", 0, 0);
        end
        check_eq("R5", "no underrun", int'(underrun), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_sweep();
        t_bufswap();
        t_underrun();
        t_disable();
        t_repeat();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule